// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives a sampling tick at sixteen times the serial bit rate from a faster reference clock. The programmed divisor is a fixed-point value with a 16-bit whole part and a 6-bit fraction, so its unit is 1/64 of a reference cycle. Written as one 22-bit number it is the whole part shifted up by six places with the fraction in the low six bits, and it equals four times the reference frequency over the bit rate. A serial transmitter or receiver uses the one-cycle tick as its oversampling strobe.

The whole and fractional parts are held in two registers on a small register bus. Each can be written and read back on its own, so software can recover the reference frequency as the divisor times the bit rate over four. Each tick period lasts the whole part in reference cycles, or one cycle more. A 6-bit accumulator takes in the fraction at every tick, and its carry stretches the next period, so the mean period equals the full fixed-point divisor. Register writes reach the running divider only at a tick boundary. A whole part of zero is invalid and stops the ticks. Dropping the enable clears the count and the accumulator.

Top module: `frac_baud_gen`

## Requirements
- R1: Register select 0 addresses the whole-part register, which keeps write bits [15:0]. Select 1 addresses the fraction register, which keeps write bits [5:0]. The read data always shows the selected register, zero-extended to 16 bits.
- R2: While enable is low, no tick is produced.
- R3: While the whole part in effect is 0, no tick is produced, even with enable high.
- R4: With a fraction of 0 and a whole part N of 1 or more, ticks come exactly every N reference cycles.
- R5: At each tick the current fraction register is added modulo 64 into an accumulator. A carry out of that sum makes the next period N+1 cycles. Over 64 consecutive periods the total is 64*N + fraction cycles.
- R6: Register writes change the period only from the next tick boundary on. No period is shorter than the whole part in effect during it.
- R7: Dropping enable clears the count and the accumulator. After enable rises, the first tick comes on the N-th cycle, counting the first enabled cycle as cycle 1, and the extension pattern restarts.
- R8: After reset, both registers read 0 and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider when high; clears its state when low |
| regAddr | input | 1 | Register select: 0 whole part, 1 fraction |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register (combinational) |
| baudTick | output | 1 | One reference-cycle tick at 16x the bit rate |

## Verification
A register write shows on the read data in the cycle after the write edge. The tick depends only on state and the enable input, so it is due in the same cycle as the count that ends a period. A whole-part register that goes from zero to valid lets the divider start one cycle after the write lands. The bench drives inputs just after the falling edge, lets them settle, and then compares the tick and read data against a behavioural model stepped one clock at a time. It also measures tick spacing in cycles to check the period, the 64-period total and the first tick after enable rises.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // divider idle: hold count, accumulator, extension at zero
    logic run;    // divider counting
  } fbgStrobes_t;

  typedef enum logic {
    SEL_INT  = 1'b0,
    SEL_FRAC = 1'b1
  } fbgRegSel_e;
endpackage

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
  import fbg_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              tick,
  output fbgStrobes_t       strobes,
  output logic [INT_W-1:0]  actInt,
  output logic [FRAC_W-1:0] nextFrac,
  output logic [DATA_W-1:0] regRdData
);
  logic [INT_W-1:0]  divIntReg;
  logic [FRAC_W-1:0] divFracReg;
  logic              idle;
  fbgRegSel_e        regSel;

  assign regSel = fbgRegSel_e'(regAddr);
  assign idle   = !enable || (actInt == '0);

  always_comb begin
    strobes.clear = idle;
    strobes.run   = !idle;
  end

  assign nextFrac = divFracReg;

  always_comb begin
    if (regSel == SEL_FRAC) regRdData = DATA_W'(divFracReg);
    else                    regRdData = DATA_W'(divIntReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divIntReg  <= '0;
      divFracReg <= '0;
    end else if (regWrEn) begin
      if (regSel == SEL_INT) divIntReg  <= regWrData[INT_W-1:0];
      else                   divFracReg <= regWrData[FRAC_W-1:0];
    end
  end

  // whole part in effect: follows the register while idle, else only at a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              actInt <= '0;
    else if (idle || tick)  actInt <= divIntReg;
  end
endmodule

// File: rtl/fbg_datapath.sv
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbgStrobes_t       strobes,
  input  logic [INT_W-1:0]  actInt,
  input  logic [FRAC_W-1:0] nextFrac,
  output logic              tick
);
  localparam int CMP_W = INT_W + 1;
  localparam int SUM_W = FRAC_W + 1;

  logic [INT_W-1:0]  cycleCnt;
  logic [FRAC_W-1:0] fracAcc;
  logic              stretch;
  logic [CMP_W-1:0]  endCount;
  logic [SUM_W-1:0]  accSum;

  assign endCount = {1'b0, actInt} - CMP_W'(1) + CMP_W'(stretch);
  assign tick     = strobes.run && ({1'b0, cycleCnt} == endCount);
  assign accSum   = {1'b0, fracAcc} + {1'b0, nextFrac};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
      fracAcc  <= '0;
      stretch  <= 1'b0;
    end else if (strobes.clear) begin
      cycleCnt <= '0;
      fracAcc  <= '0;
      stretch  <= 1'b0;
    end else if (tick) begin
      cycleCnt <= '0;
      fracAcc  <= accSum[FRAC_W-1:0];
      stretch  <= accSum[FRAC_W];
    end else begin
      cycleCnt <= cycleCnt + INT_W'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              baudTick
);
  fbgStrobes_t       strobes;
  logic [INT_W-1:0]  actInt;
  logic [FRAC_W-1:0] nextFrac;

  fbg_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .tick(baudTick),
    .strobes(strobes), .actInt(actInt), .nextFrac(nextFrac),
    .regRdData(regRdData)
  );

  fbg_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .actInt(actInt),
    .nextFrac(nextFrac), .tick(baudTick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              baudTick,
  input logic [INT_W-1:0]  actInt
);
  localparam int GAP_W = INT_W + 2;

  logic [GAP_W-1:0] gapCnt;
  logic             seenTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      seenTick <= 1'b0;
    end else if (!enable || actInt == '0) begin
      gapCnt   <= '0;
      seenTick <= 1'b0;
    end else if (baudTick) begin
      gapCnt   <= GAP_W'(1);
      seenTick <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt   <= gapCnt + GAP_W'(1);
    end
  end

  p_idle_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !baudTick);

  p_zero_div_no_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (actInt == '0) |-> !baudTick);

  p_frac_width_r1: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> (regRdData[DATA_W-1:FRAC_W] == '0));

  p_int_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!regAddr && $past(regWrEn && !regAddr)) |-> (regRdData == $past(regWrData)));

  p_period_floor_r6: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && seenTick) |-> (gapCnt >= GAP_W'(actInt)));

  p_period_ceiling_r5: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && seenTick) |-> (gapCnt <= GAP_W'(actInt) + GAP_W'(1)));
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .regAddr(regAddr),
  .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
  .baudTick(baudTick), .actInt(actInt)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        regAddr = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        baudTick;

  frac_baud_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .baudTick(baudTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R8";

  // behavioural model state
  int mInt = 0, mFrac = 0, aInt = 0, cnt = 0, acc = 0, ext = 0;
  int cycleNo = 0, ticksSeen = 0, lastTickCycle = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycleNo);
    end
  endtask

  // inputs already driven after a falling edge; compare, advance model, wait
  task automatic step();
    bit idle, expTick;
    int expRd, sum;
    #1;
    idle    = !enable || (aInt == 0);
    expTick = !idle && (cnt == aInt - 1 + ext);
    expRd   = regAddr ? mFrac : mInt;
    check(baudTick == expTick, curReq, int'(baudTick), int'(expTick));
    check(int'(regRdData) == expRd, curReq, int'(regRdData), expRd);
    cycleNo++;
    if (baudTick) begin ticksSeen++; lastTickCycle = cycleNo; end
    if (idle) begin
      cnt = 0; acc = 0; ext = 0; aInt = mInt;
    end else if (expTick) begin
      cnt = 0; sum = acc + mFrac; acc = sum % 64; ext = (sum >= 64); aInt = mInt;
    end else begin
      cnt++;
    end
    if (regWrEn) begin
      if (!regAddr) mInt = int'(regWrData);
      else          mFrac = int'(regWrData[5:0]);
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic writeReg(input bit sel, input logic [15:0] val);
    regAddr = sel; regWrData = val; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    int target;
    target = ticksSeen + n;
    for (int i = 0; i < 5000 && ticksSeen < target; i++) step();
  endtask

  initial begin
    int t0, startCyc, startTicks;
    // R8: reset state
    @(negedge clk);
    #1;
    check(baudTick == 1'b0, "R8", int'(baudTick), 0);
    check(regRdData == 16'h0, "R8", int'(regRdData), 0);
    regAddr = 1'b1;
    #1;
    check(regRdData == 16'h0, "R8", int'(regRdData), 0);
    regAddr = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    run(3);

    // R1: register widths and readback
    curReq = "R1";
    writeReg(1'b0, 16'hABCD);
    run(1);
    check(regRdData == 16'hABCD, "R1", int'(regRdData), 'hABCD);
    writeReg(1'b1, 16'hFFFF);
    run(1);
    check(regRdData == 16'h003F, "R1", int'(regRdData), 'h3F);

    // R3: zero whole part keeps the divider silent
    curReq = "R3";
    writeReg(1'b0, 16'd0);
    enable = 1'b1;
    startTicks = ticksSeen;
    run(40);
    check(ticksSeen == startTicks, "R3", ticksSeen - startTicks, 0);

    // R2: enable low with a valid divisor
    curReq = "R2";
    enable = 1'b0;
    writeReg(1'b0, 16'd2);
    writeReg(1'b1, 16'd0);
    startTicks = ticksSeen;
    run(40);
    check(ticksSeen == startTicks, "R2", ticksSeen - startTicks, 0);

    // R4: integer divisor 5, fraction 0
    curReq = "R4";
    writeReg(1'b0, 16'd5);
    enable = 1'b1;
    waitTicks(1);
    t0 = lastTickCycle;
    waitTicks(1);
    check(lastTickCycle - t0 == 5, "R4", lastTickCycle - t0, 5);
    waitTicks(3);

    // R4: divisor 1 ticks every cycle
    writeReg(1'b0, 16'd1);
    waitTicks(2);
    t0 = lastTickCycle;
    waitTicks(1);
    check(lastTickCycle - t0 == 1, "R4", lastTickCycle - t0, 1);

    // R5: 3 + 21/64 over 64 periods
    curReq = "R5";
    enable = 1'b0;
    writeReg(1'b0, 16'd3);
    writeReg(1'b1, 16'd21);
    run(2);
    enable = 1'b1;
    waitTicks(1);
    t0 = lastTickCycle;
    waitTicks(64);
    check(lastTickCycle - t0 == 213, "R5", lastTickCycle - t0, 213);

    // R6: change mid-period; old period completes, new one follows
    curReq = "R6";
    writeReg(1'b1, 16'd0);
    waitTicks(2);
    writeReg(1'b0, 16'd9);
    waitTicks(1);
    t0 = lastTickCycle;
    waitTicks(1);
    check(lastTickCycle - t0 == 9, "R6", lastTickCycle - t0, 9);
    writeReg(1'b0, 16'd0);
    waitTicks(1);
    startTicks = ticksSeen;
    run(30);
    check(ticksSeen == startTicks, "R6", ticksSeen - startTicks, 0);

    // R7: re-enable clears accumulator; first tick on cycle N
    curReq = "R7";
    enable = 1'b0;
    writeReg(1'b0, 16'd4);
    writeReg(1'b1, 16'd32);
    run(2);
    enable = 1'b1;
    startCyc = cycleNo;
    waitTicks(1);
    check(lastTickCycle - startCyc == 4, "R7", lastTickCycle - startCyc, 4);
    t0 = lastTickCycle;
    waitTicks(2);
    check(lastTickCycle - t0 == 9, "R7", lastTickCycle - t0, 9);
    enable = 1'b0;
    run(3);
    enable = 1'b1;
    startCyc = cycleNo;
    waitTicks(1);
    check(lastTickCycle - startCyc == 4, "R7", lastTickCycle - startCyc, 4);
    run(20);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule